// File: doc/BRIEF.md
# Two-Wire Expander Register Front-End

This block sits behind a bit-level two-wire-bus engine inside a 16-bit I/O expander slave. The engine hands it decoded events: start (first or repeated), stop, a received byte, and a request for the next read byte. The block decides whether the transaction is addressed to this device. On writes it loads a command pointer and then stores data bytes into the addressed register. On reads it returns the addressed register. It answers each received byte with an acknowledge or a not-acknowledge pulse, and each read request with a data byte.

The register space has two banks. The basic bank is selected by the low command bits and holds four pairs, one register per port: input (read only), output, polarity inversion and configuration. The extended bank is selected through command bit 6 and holds a pull-select pair and an interrupt-mask pair. Both of those reset to all ones. In a burst, the pointer alternates between the two registers of a pair. The pointer survives stop and repeated start, so a command written in one transaction also steers a later read.

The control state machine has six states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: the slave-address byte is expected.
- `ST_CMD`: the command byte is expected.
- `ST_WDATA`: write data bytes are expected.
- `ST_RDATA`: read data is being served.
- `ST_SKIP`: the address did not match, so bytes are ignored until the next start.

Its transitions are:
- A stop from any state goes to `ST_IDLE`.
- A start from any state goes to `ST_ADDR`.
- In `ST_ADDR`, a byte with a matching address goes to `ST_RDATA` when the read/write bit is 1 and to `ST_CMD` when it is 0. A byte with a non-matching address goes to `ST_SKIP`.
- In `ST_CMD`, a byte goes to `ST_WDATA`.
- All other events keep the current state.

Top module: `gpx_reg_front`

## Requirements
- R1: An address byte is accepted only when bits [7:1] equal 4'b0100 followed by `strap_addr[2:0]`. A non-matching address byte gets a not-acknowledge pulse. Every byte after it is ignored until the next start: no response is given and no register changes.
- R2: Bit 0 of a matching address byte selects the direction: 1 starts a read phase and 0 starts a write phase. Both are acknowledged.
- R3: In a write phase, the first byte after the address is acknowledged and loaded into the pointer register. The pointer is never returned on a read.
- R4: Pointer values 00h and 01h select input port 0 and port 1. A read of an input register returns `pin_in` XOR polarity for that port, and a write to it is acknowledged but changes nothing. Values 02h/03h select output, 04h/05h select polarity and 06h/07h select configuration, each as port 0/port 1.
- R5: Pointer values 48h/49h select pull-select port 0/port 1, and 4Ah/4Bh select interrupt-mask port 0/port 1. These registers change only when they are written.
- R6: After reset, output, configuration, pull-select and interrupt-mask are all ones, polarity is zero and the pointer is 00h.
- R7: After each data byte written or read at a decoded pointer, pointer bit 0 toggles, so that port 0 and port 1 of a pair alternate.
- R8: A data write at an undecoded pointer is not acknowledged and changes nothing. A read at an undecoded pointer returns 00h.
- R9: A stop or a repeated start ends the burst but keeps the pointer.
- R10: The acknowledge or not-acknowledge pulse appears in the cycle after the byte event. The read data and its valid pulse appear in the cycle after the read request.
- R11: A read request outside a read phase produces no read-valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 3 | Hardware address strap bits |
| pin_in | input | 16 | Pin levels, {port1, port0} |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_byte_valid | input | 1 | A byte was received |
| ev_byte | input | 8 | Received byte |
| ev_rd_req | input | 1 | Engine requests the next read byte |
| ack_p | output | 1 | Acknowledge the last byte |
| nack_p | output | 1 | Do not acknowledge the last byte |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| out_q | output | 16 | Output register pair |
| pol_q | output | 16 | Polarity register pair |
| cfg_q | output | 16 | Configuration register pair |
| pull_q | output | 16 | Pull-select register pair |
| mask_q | output | 16 | Interrupt-mask register pair |

## Verification
The assertions assume that the bit-level engine raises at most one event per cycle: start, stop, byte and read request never coincide. They also assume that `ev_byte` is only meaningful while its valid strobe is high. The stimulus drives every event as a single-cycle pulse on the falling clock edge, with at least one cycle between events, so that this assumption always holds. The strap pins and the pin levels stay constant during a run, so that expected input reads can be computed ahead of time.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b0100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } gpx_state_t;

    typedef enum logic [2:0] {
        RG_IN,
        RG_OUT,
        RG_POL,
        RG_CFG,
        RG_PULL,
        RG_MASK,
        RG_NONE
    } gpx_reg_t;

    // Map a pointer value onto a register kind; bit 0 picks the port.
    function automatic gpx_reg_t gpx_decode(input logic [7:0] c);
        gpx_reg_t k;
        if (c[7:3] == 5'b00000) begin
            unique case (c[2:1])
                2'd0: k = RG_IN;
                2'd1: k = RG_OUT;
                2'd2: k = RG_POL;
                default: k = RG_CFG;
            endcase
        end else if (c[7:2] == 6'b010010) begin
            k = c[1] ? RG_MASK : RG_PULL;
        end else begin
            k = RG_NONE;
        end
        return k;
    endfunction

endpackage

// File: rtl/gpx_addr_match.sv
module gpx_addr_match
    import gpx_pkg::*;
#(
    parameter int STRAP_W = 3
) (
    input  logic [7:0]         byte_in,
    input  logic [STRAP_W-1:0] strap,
    output logic               hit,
    output logic               is_read
);
    localparam int PFX_W = 7 - STRAP_W;

    assign hit     = (byte_in[7:1] == {DEV_PREFIX[PFX_W-1:0], strap});
    assign is_read = byte_in[0];
endmodule

// File: rtl/gpx_reg_bank.sv
module gpx_reg_bank
    import gpx_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int NPORT  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              ptr,
    input  logic [PORT_W-1:0]       wr_data,
    input  logic [NPORT*PORT_W-1:0] pin_in,
    output logic                    hit,
    output logic [PORT_W-1:0]       rd_data,
    output logic [NPORT*PORT_W-1:0] out_q,
    output logic [NPORT*PORT_W-1:0] pol_q,
    output logic [NPORT*PORT_W-1:0] cfg_q,
    output logic [NPORT*PORT_W-1:0] pull_q,
    output logic [NPORT*PORT_W-1:0] mask_q
);
    localparam logic [PORT_W-1:0] ONES  = '1;
    localparam logic [PORT_W-1:0] ZEROS = '0;

    gpx_reg_t kind;
    logic     sel;

    assign kind = gpx_decode(ptr);
    assign sel  = ptr[0];
    assign hit  = (kind != RG_NONE);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [PORT_W-1:0] out_r, pol_r, cfg_r, pull_r, mask_r;
        logic              we;

        assign we = wr_en && (int'(sel) == p);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_r  <= ONES;
                pol_r  <= ZEROS;
                cfg_r  <= ONES;
                pull_r <= ONES;
                mask_r <= ONES;
            end else if (we) begin
                unique case (kind)
                    RG_OUT:  out_r  <= wr_data;
                    RG_POL:  pol_r  <= wr_data;
                    RG_CFG:  cfg_r  <= wr_data;
                    RG_PULL: pull_r <= wr_data;
                    RG_MASK: mask_r <= wr_data;
                    default: ;
                endcase
            end
        end

        assign out_q [p*PORT_W +: PORT_W] = out_r;
        assign pol_q [p*PORT_W +: PORT_W] = pol_r;
        assign cfg_q [p*PORT_W +: PORT_W] = cfg_r;
        assign pull_q[p*PORT_W +: PORT_W] = pull_r;
        assign mask_q[p*PORT_W +: PORT_W] = mask_r;
    end

    always_comb begin
        unique case (kind)
            RG_IN:   rd_data = pin_in[sel*PORT_W +: PORT_W] ^ pol_q[sel*PORT_W +: PORT_W];
            RG_OUT:  rd_data = out_q [sel*PORT_W +: PORT_W];
            RG_POL:  rd_data = pol_q [sel*PORT_W +: PORT_W];
            RG_CFG:  rd_data = cfg_q [sel*PORT_W +: PORT_W];
            RG_PULL: rd_data = pull_q[sel*PORT_W +: PORT_W];
            RG_MASK: rd_data = mask_q[sel*PORT_W +: PORT_W];
            default: rd_data = ZEROS;
        endcase
    end
endmodule

// File: rtl/gpx_reg_front.sv
module gpx_reg_front
    import gpx_pkg::*;
#(
    parameter int PORT_W  = 8,
    parameter int STRAP_W = 3,
    localparam int NPORT  = 2,
    localparam int BUS_W  = NPORT * PORT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic [BUS_W-1:0]   pin_in,
    input  logic               ev_start,
    input  logic               ev_stop,
    input  logic               ev_byte_valid,
    input  logic [7:0]         ev_byte,
    input  logic               ev_rd_req,
    output logic               ack_p,
    output logic               nack_p,
    output logic               rd_valid,
    output logic [7:0]         rd_data,
    output logic [BUS_W-1:0]   out_q,
    output logic [BUS_W-1:0]   pol_q,
    output logic [BUS_W-1:0]   cfg_q,
    output logic [BUS_W-1:0]   pull_q,
    output logic [BUS_W-1:0]   mask_q
);
    gpx_state_t        st, st_n;
    logic [7:0]        ptr;
    logic              addr_hit, addr_rd;
    logic              bank_hit;
    logic [PORT_W-1:0] bank_rd;
    logic              bus_evt;
    logic              byte_ev, req_ev;
    logic              bank_we;

    // Start/stop take priority over byte and read events in the same cycle.
    assign bus_evt = ev_start || ev_stop;
    assign byte_ev = ev_byte_valid && !bus_evt;
    assign req_ev  = ev_rd_req && !bus_evt;
    assign bank_we = byte_ev && (st == ST_WDATA) && bank_hit;

    gpx_addr_match #(.STRAP_W(STRAP_W)) u_match (
        .byte_in (ev_byte),
        .strap   (strap_addr),
        .hit     (addr_hit),
        .is_read (addr_rd)
    );

    gpx_reg_bank #(.PORT_W(PORT_W), .NPORT(NPORT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_we),
        .ptr     (ptr),
        .wr_data (ev_byte[PORT_W-1:0]),
        .pin_in  (pin_in),
        .hit     (bank_hit),
        .rd_data (bank_rd),
        .out_q   (out_q),
        .pol_q   (pol_q),
        .cfg_q   (cfg_q),
        .pull_q  (pull_q),
        .mask_q  (mask_q)
    );

    // Next-state logic.
    always_comb begin
        st_n = st;
        if (ev_stop) begin
            st_n = ST_IDLE;
        end else if (ev_start) begin
            st_n = ST_ADDR;
        end else begin
            unique case (st)
                ST_ADDR: begin
                    if (byte_ev) begin
                        if (!addr_hit)    st_n = ST_SKIP;
                        else if (addr_rd) st_n = ST_RDATA;
                        else              st_n = ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (byte_ev) st_n = ST_WDATA;
                end
                default: ;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Outputs and pointer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_p    <= 1'b0;
            nack_p   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            ptr      <= '0;
        end else begin
            ack_p    <= 1'b0;
            nack_p   <= 1'b0;
            rd_valid <= 1'b0;
            unique case (st)
                ST_ADDR: begin
                    if (byte_ev) begin
                        ack_p  <= addr_hit;
                        nack_p <= !addr_hit;
                    end
                end
                ST_CMD: begin
                    if (byte_ev) begin
                        ptr   <= ev_byte;
                        ack_p <= 1'b1;
                    end
                end
                ST_WDATA: begin
                    if (byte_ev) begin
                        ack_p  <= bank_hit;
                        nack_p <= !bank_hit;
                        if (bank_hit) ptr[0] <= !ptr[0];
                    end
                end
                ST_RDATA: begin
                    if (req_ev) begin
                        rd_valid <= 1'b1;
                        rd_data  <= bank_hit ? 8'(bank_rd) : 8'h00;
                        if (bank_hit) ptr[0] <= !ptr[0];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpx_reg_front_chk.sv
module gpx_reg_front_chk
    import gpx_pkg::*;
#(
    parameter int STRAP_W = 3,
    parameter int BUS_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input gpx_state_t         st,
    input logic [STRAP_W-1:0] strap_addr,
    input logic               ev_start,
    input logic               ev_stop,
    input logic               ev_byte_valid,
    input logic [7:0]         ev_byte,
    input logic               ev_rd_req,
    input logic               ack_p,
    input logic               nack_p,
    input logic               rd_valid,
    input logic [7:0]         rd_data,
    input logic               bank_hit,
    input logic [BUS_W-1:0]   mask_q
);
    localparam int PFX_W = 7 - STRAP_W;

    logic quiet;
    assign quiet = !ev_start && !ev_stop;

    // Input assumption: one bus event per cycle.
    p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_stop, ev_byte_valid, ev_rd_req}));

    p_addr_miss_nack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR && ev_byte_valid && quiet &&
         ev_byte[7:1] != {DEV_PREFIX[PFX_W-1:0], strap_addr})
        |=> (nack_p && !ack_p));

    p_skip_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP && quiet) |=> (!ack_p && !nack_p && !rd_valid));

    p_addr_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR && ev_byte_valid && quiet &&
         ev_byte == {DEV_PREFIX[PFX_W-1:0], strap_addr, 1'b1})
        |=> (ack_p && st == ST_RDATA));

    p_mask_only_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask_q) |-> $past(ev_byte_valid));

    p_undecoded_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RDATA && ev_rd_req && quiet && !bank_hit)
        |=> (rd_valid && rd_data == 8'h00));

    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (st == ST_IDLE));

    p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RDATA && ev_rd_req && quiet) |=> rd_valid);

    p_no_read_outside_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_RDATA && ev_rd_req) |=> !rd_valid);
endmodule

bind gpx_reg_front gpx_reg_front_chk #(.STRAP_W(STRAP_W), .BUS_W(BUS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st            (st),
    .strap_addr    (strap_addr),
    .ev_start      (ev_start),
    .ev_stop       (ev_stop),
    .ev_byte_valid (ev_byte_valid),
    .ev_byte       (ev_byte),
    .ev_rd_req     (ev_rd_req),
    .ack_p         (ack_p),
    .nack_p        (nack_p),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .bank_hit      (bank_hit),
    .mask_q        (mask_q)
);

// File: tb/gpx_reg_front_bench.sv
module gpx_reg_front_bench;

    localparam logic [1:0] K_S = 2'd0, K_P = 2'd1, K_B = 2'd2, K_R = 2'd3;
    localparam logic [1:0] NO = 2'd0, AK = 2'd1, NK = 2'd2;
    localparam logic [15:0] PINS = 16'hA53C;

    function automatic logic [23:0] mk(input logic [1:0] k, input logic [7:0] b,
                                       input logic [7:0] e, input logic [1:0] r,
                                       input logic [3:0] q);
        return {k, b, e, r, q};
    endfunction

    localparam int NV = 60;
    // Strap 3'b101: write address 4Ah, read address 4Bh.
    localparam logic [23:0] VEC [NV] = '{
        // R7 output burst alternates ports; R3 command load; R2 write
        mk(K_S,8'h00,8'h00,NO,4'd0), mk(K_B,8'h4A,8'h00,AK,4'd2),
        mk(K_B,8'h02,8'h00,AK,4'd3), mk(K_B,8'h12,8'h00,AK,4'd4),
        mk(K_B,8'h34,8'h00,AK,4'd7), mk(K_B,8'h56,8'h00,AK,4'd7),
        mk(K_P,8'h00,8'h00,NO,4'd0),
        // R9 pointer kept across stop; R2 read; R10 read latency
        mk(K_S,8'h00,8'h00,NO,4'd0), mk(K_B,8'h4B,8'h00,AK,4'd2),
        mk(K_R,8'h00,8'h34,AK,4'd9), mk(K_R,8'h00,8'h56,AK,4'd7),
        mk(K_R,8'h00,8'h34,AK,4'd10), mk(K_P,8'h00,8'h00,NO,4'd0),
        // R4 polarity write, then input read through repeated start (R9)
        mk(K_S,8'h00,8'h00,NO,4'd0), mk(K_B,8'h4A,8'h00,AK,4'd1),
        mk(K_B,8'h04,8'h00,AK,4'd3), mk(K_B,8'hFF,8'h00,AK,4'd4),
        mk(K_B,8'h00,8'h00,AK,4'd4), mk(K_P,8'h00,8'h00,NO,4'd0),
        mk(K_S,8'h00,8'h00,NO,4'd0), mk(K_B,8'h4A,8'h00,AK,4'd1),
        mk(K_B,8'h00,8'h00,AK,4'd3), mk(K_S,8'h00,8'h00,NO,4'd0),
        mk(K_B,8'h4B,8'h00,AK,4'd2), mk(K_R,8'h00,8'hC3,AK,4'd4),
        mk(K_R,8'h00,8'hA5,AK,4'd4), mk(K_P,8'h00,8'h00,NO,4'd0),
        // R5 interrupt-mask pair write, pull-select pair read
        mk(K_S,8'h00,8'h00,NO,4'd0), mk(K_B,8'h4A,8'h00,AK,4'd1),
        mk(K_B,8'h4A,8'h00,AK,4'd5), mk(K_B,8'h0F,8'h00,AK,4'd5),
        mk(K_B,8'hF0,8'h00,AK,4'd5), mk(K_P,8'h00,8'h00,NO,4'd0),
        mk(K_S,8'h00,8'h00,NO,4'd0), mk(K_B,8'h4A,8'h00,AK,4'd1),
        mk(K_B,8'h49,8'h00,AK,4'd5), mk(K_P,8'h00,8'h00,NO,4'd0),
        mk(K_S,8'h00,8'h00,NO,4'd0), mk(K_B,8'h4B,8'h00,AK,4'd2),
        mk(K_R,8'h00,8'hFF,AK,4'd5), mk(K_R,8'h00,8'hFF,AK,4'd6),
        mk(K_P,8'h00,8'h00,NO,4'd0),
        // R8 undecoded pointer: write not acknowledged, read gives 00h
        mk(K_S,8'h00,8'h00,NO,4'd0), mk(K_B,8'h4A,8'h00,AK,4'd1),
        mk(K_B,8'h20,8'h00,AK,4'd3), mk(K_B,8'h77,8'h00,NK,4'd8),
        mk(K_S,8'h00,8'h00,NO,4'd0), mk(K_B,8'h4B,8'h00,AK,4'd2),
        mk(K_R,8'h00,8'h00,AK,4'd8), mk(K_P,8'h00,8'h00,NO,4'd0),
        // R4 write to input register is acknowledged and ignored
        mk(K_S,8'h00,8'h00,NO,4'd0), mk(K_B,8'h4A,8'h00,AK,4'd1),
        mk(K_B,8'h00,8'h00,AK,4'd3), mk(K_B,8'h99,8'h00,AK,4'd4),
        mk(K_P,8'h00,8'h00,NO,4'd0), mk(K_S,8'h00,8'h00,NO,4'd0),
        mk(K_B,8'h4B,8'h00,AK,4'd2), mk(K_R,8'h00,8'hA5,AK,4'd4),
        mk(K_R,8'h00,8'hC3,AK,4'd4), mk(K_P,8'h00,8'h00,NO,4'd0)
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  strap_addr = 3'b101;
    logic [15:0] pin_in = PINS;
    logic        ev_start = 1'b0, ev_stop = 1'b0, ev_byte_valid = 1'b0, ev_rd_req = 1'b0;
    logic [7:0]  ev_byte = 8'h00;
    logic        ack_p, nack_p, rd_valid;
    logic [7:0]  rd_data;
    logic [15:0] out_q, pol_q, cfg_q, pull_q, mask_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    gpx_reg_front u_gpx_reg_front (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .pin_in(pin_in),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte_valid(ev_byte_valid),
        .ev_byte(ev_byte), .ev_rd_req(ev_rd_req),
        .ack_p(ack_p), .nack_p(nack_p), .rd_valid(rd_valid), .rd_data(rd_data),
        .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q), .pull_q(pull_q), .mask_q(mask_q)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pulse one event for one cycle, then check the registered response.
    task automatic step(input logic [1:0] k, input logic [7:0] b, input logic [7:0] e,
                        input logic [1:0] r, input string req);
        @(negedge clk);
        ev_start      = (k == K_S);
        ev_stop       = (k == K_P);
        ev_byte_valid = (k == K_B);
        ev_rd_req     = (k == K_R);
        ev_byte       = b;
        @(negedge clk);
        ev_start = 1'b0; ev_stop = 1'b0; ev_byte_valid = 1'b0; ev_rd_req = 1'b0;
        if (k == K_B) begin
            check({ack_p, nack_p} == {r == AK, r == NK}, req,
                  {30'd0, ack_p, nack_p}, {30'd0, r == AK, r == NK});
        end else if (k == K_R) begin
            if (r == AK)
                check(rd_valid && rd_data == e, req, {23'd0, rd_valid, rd_data},
                      {23'd0, 1'b1, e});
            else
                check(!rd_valid, req, {31'd0, rd_valid}, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R6 reset values
        check(out_q == 16'hFFFF && cfg_q == 16'hFFFF, "R6", {out_q, cfg_q}, 32'hFFFFFFFF);
        check(pull_q == 16'hFFFF && mask_q == 16'hFFFF, "R6", {pull_q, mask_q}, 32'hFFFFFFFF);
        check(pol_q == 16'h0000 && !ack_p && !rd_valid, "R6", {16'd0, pol_q}, 32'd0);
        rst_n = 1'b1;
        // R6 pointer resets to 00h: first read returns input port 0
        step(K_S, 8'h00, 8'h00, NO, "R6");
        step(K_B, 8'h4B, 8'h00, AK, "R2");
        step(K_R, 8'h00, 8'h3C, AK, "R6");
        step(K_P, 8'h00, 8'h00, NO, "R9");

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VEC[i];
            step(v[23:22], v[21:14], v[13:6], v[5:4], $sformatf("R%0d vec%0d", v[3:0], i));
        end

        // R1 foreign address: nack, then silence and no register change
        step(K_S, 8'h00, 8'h00, NO, "R1");
        step(K_B, 8'h40, 8'h00, NK, "R1");
        step(K_B, 8'h02, 8'h00, NO, "R1");
        step(K_B, 8'h99, 8'h00, NO, "R1");
        step(K_P, 8'h00, 8'h00, NO, "R1");
        check(out_q == 16'h3456, "R1 out", {16'd0, out_q}, 32'h3456);

        // R4 configuration pair write
        step(K_S, 8'h00, 8'h00, NO, "R4");
        step(K_B, 8'h4A, 8'h00, AK, "R2");
        step(K_B, 8'h06, 8'h00, AK, "R3");
        step(K_B, 8'h0F, 8'h00, AK, "R4");
        step(K_B, 8'hF0, 8'h00, AK, "R4");
        step(K_P, 8'h00, 8'h00, NO, "R9");
        check(cfg_q == 16'hF00F, "R4 cfg", {16'd0, cfg_q}, 32'hF00F);
        check(pol_q == 16'h00FF, "R4 pol", {16'd0, pol_q}, 32'h00FF);
        check(mask_q == 16'hF00F, "R5 mask", {16'd0, mask_q}, 32'hF00F);
        check(pull_q == 16'hFFFF, "R5 pull", {16'd0, pull_q}, 32'hFFFF);

        // R11 read request while idle
        step(K_R, 8'h00, 8'h00, NO, "R11");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule